// File: doc/BRIEF.md
# Compact Integer ALU with Result Flags

This block is the integer arithmetic and logic unit of a small load/store processor datapath. It takes two operands and a three-bit operation code. In the same cycle, with no registers, it returns a result word and two flags: a zero flag and a signed-overflow flag. It performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than. A branch-on-equal is carried out by issuing the subtract code and reading the zero flag.

Subtraction has no separate datapath. The top bit of the operation code does two jobs: it inverts the second operand and it supplies the carry into the least significant bit, so the adder forms A + ~B + 1. Set-on-less-than reuses that subtraction. Its one-bit answer is taken from the sign of the difference, corrected for overflow, and is routed only into result bit 0. The block holds no state, so it has no states and no transitions. Its only control path is the decode from the operation code to an operand-negate bit, a result source and an overflow enable.

Top module: `int_alu`

## Requirements
- R1: Operation code 000 gives result = A AND B, bit by bit.
- R2: Operation code 001 gives result = A OR B, bit by bit.
- R3: Operation code 010 gives result = (A + B) modulo 2^WIDTH.
- R4: Operation code 110 gives result = (A − B) modulo 2^WIDTH. It is formed by adding the inverted B with a carry-in of 1, both taken from operation-code bit 2.
- R5: Operation code 111 gives result bit 0 = 1 exactly when A < B as signed two's-complement numbers, including when A − B overflows. All other result bits are 0.
- R6: The zero flag is 1 exactly when every result bit is 0, for every operation code. With code 110 it is therefore 1 exactly when A equals B.
- R7: With code 010 the overflow flag is 1 exactly when A and B have the same sign and the sum's sign differs from it.
- R8: With code 110 the overflow flag is 1 exactly when A and B have different signs and the difference's sign differs from the sign of A.
- R9: The overflow flag is 0 for codes 000, 001, 111 and for every unused code.
- R10: The unused codes 011, 100 and 101 give an all-zero result, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend for subtract and compare) |
| opnd_b | input | WIDTH | Second operand |
| op_code | input | 3 | Operation select; bit 2 is the operand-negate and carry-in control |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | 1 when all result bits are 0 |
| ovf_flag | output | 1 | Signed overflow for add and subtract |

## Verification
The bench builds the block with WIDTH left at 32, so the sign-bit carries and the extreme values 0x7FFFFFFF and 0x80000000 are the real ones. Crossing those extremes with 0, 1 and all-ones over all eight codes covers several cases directly. Both overflow directions of add and subtract are reached. A compare whose subtraction overflows is reached, where only the overflow correction gives the right answer. The equal-operand subtract that drives the zero flag is also reached. Random operand pairs on every code then cover carry patterns across the whole chain.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_AND,
        SEL_OR,
        SEL_SUM,
        SEL_LESS
    } alu_sel_e;

    typedef struct packed {
        logic     b_negate;
        alu_sel_e sel;
        logic     ovf_en;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [2:0] op_code,
    output alu_ctrl_t  ctrl
);

    always_comb begin
        ctrl.b_negate = op_code[2];
        ctrl.sel      = SEL_NONE;
        ctrl.ovf_en   = 1'b0;
        unique case (op_code)
            OP_AND: ctrl.sel = SEL_AND;
            OP_OR:  ctrl.sel = SEL_OR;
            OP_ADD: begin
                ctrl.sel    = SEL_SUM;
                ctrl.ovf_en = 1'b1;
            end
            OP_SUB: begin
                ctrl.sel    = SEL_SUM;
                ctrl.ovf_en = 1'b1;
            end
            OP_SLT: ctrl.sel = SEL_LESS;
            default: ctrl.sel = SEL_NONE;
        endcase
    end

    // An operation that selects the compare output must subtract.
    always_comb begin
        p_less_negates_r5: assert (ctrl.sel != SEL_LESS || ctrl.b_negate)
            else $error("compare selected without operand negate");
    end

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_first,
    output logic [WIDTH:0]   carry
);

    always_comb begin
        carry[0] = carry_first;
        for (int i = 0; i < WIDTH; i++) begin
            carry[i+1] = (a_in[i] & b_in[i]) |
                         (a_in[i] & carry[i]) |
                         (b_in[i] & carry[i]);
        end
    end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
    import alu_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  logic     b_eff_bit,
    input  logic     carry_in,
    input  logic     less_in,
    input  alu_sel_e sel,
    output logic     sum_bit,
    output logic     res_bit
);

    assign sum_bit = a_bit ^ b_eff_bit ^ carry_in;

    always_comb begin
        unique case (sel)
            SEL_AND:  res_bit = a_bit & b_bit;
            SEL_OR:   res_bit = a_bit | b_bit;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_in,
    output logic             is_zero
);

    assign is_zero = ~|word_in;

endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);

    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic             ovf_raw;
    logic             less_bit;

    alu_op_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    assign b_eff = opnd_b ^ {WIDTH{ctrl.b_negate}};

    alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .a_in        (opnd_a),
        .b_in        (b_eff),
        .carry_first (ctrl.b_negate),
        .carry       (carry)
    );

    // Overflow: carry into the sign bit differs from carry out of it.
    assign ovf_raw  = carry[MSB] ^ carry[WIDTH];
    // Signed less-than, corrected when the subtraction overflows.
    assign less_bit = sum[MSB] ^ ovf_raw;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            alu_bit_cell u_cell (
                .a_bit     (opnd_a[i]),
                .b_bit     (opnd_b[i]),
                .b_eff_bit (b_eff[i]),
                .carry_in  (carry[i]),
                .less_in   (less_bit),
                .sel       (ctrl.sel),
                .sum_bit   (sum[i]),
                .res_bit   (result[i])
            );
        end else begin : g_upper
            alu_bit_cell u_cell (
                .a_bit     (opnd_a[i]),
                .b_bit     (opnd_b[i]),
                .b_eff_bit (b_eff[i]),
                .carry_in  (carry[i]),
                .less_in   (1'b0),
                .sel       (ctrl.sel),
                .sum_bit   (sum[i]),
                .res_bit   (result[i])
            );
        end
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_in (result),
        .is_zero (zero_flag)
    );

    assign ovf_flag = ctrl.ovf_en & ovf_raw;

    always_comb begin
        p_sub_diff_r4: assert (op_code != OP_SUB || result == opnd_a - opnd_b)
            else $error("subtract result mismatch");
        p_slt_upper_r5: assert (op_code != OP_SLT || result[MSB:1] == '0)
            else $error("compare upper bits not zero");
        p_equal_zero_r6: assert (op_code != OP_SUB || opnd_a != opnd_b || zero_flag)
            else $error("equal operands without zero flag");
        p_add_ovf_sign_r7: assert (op_code != OP_ADD || !ovf_flag || opnd_a[MSB] == opnd_b[MSB])
            else $error("add overflow with mixed signs");
        p_sub_ovf_sign_r8: assert (op_code != OP_SUB || !ovf_flag || opnd_a[MSB] != opnd_b[MSB])
            else $error("subtract overflow with equal signs");
        p_no_overflow_r9: assert (op_code == OP_ADD || op_code == OP_SUB || !ovf_flag)
            else $error("overflow on non-arithmetic code");
    end

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;

    localparam int W = 32;

    typedef struct {
        logic [2:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp_res;
        logic         exp_z;
        logic         exp_v;
        string        res_tag;
        string        v_tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [2:0]   op_code = 3'b000;
    logic [W-1:0] result;
    logic         zero_flag;
    logic         ovf_flag;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    int_alu #(.WIDTH(W)) u0 (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_code   (op_code),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        item_t        it;
        logic [W-1:0] s;
        @(posedge clk);
        #1;
        opnd_a  = a;
        opnd_b  = b;
        op_code = op;
        it.op = op; it.a = a; it.b = b;
        it.exp_v = 1'b0;
        it.v_tag = "R9";
        case (op)
            3'b000: begin it.exp_res = a & b; it.res_tag = "R1"; end
            3'b001: begin it.exp_res = a | b; it.res_tag = "R2"; end
            3'b010: begin
                s = a + b;
                it.exp_res = s; it.res_tag = "R3";
                it.exp_v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
                it.v_tag = "R7";
            end
            3'b110: begin
                s = a - b;
                it.exp_res = s; it.res_tag = "R4";
                it.exp_v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
                it.v_tag = "R8";
            end
            3'b111: begin
                it.exp_res = ($signed(a) < $signed(b)) ? {{(W-1){1'b0}}, 1'b1} : '0;
                it.res_tag = "R5";
            end
            default: begin it.exp_res = '0; it.res_tag = "R10"; end
        endcase
        it.exp_z = (it.exp_res == '0);
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, away from input changes.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (result !== it.exp_res) begin
                    n_fail++;
                    $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h",
                             it.res_tag, it.op, it.a, it.b, result, it.exp_res);
                end
                n_checks++;
                if (zero_flag !== it.exp_z) begin
                    n_fail++;
                    $display("FAIL R6 op=%b a=%h b=%h zero actual=%b expected=%b",
                             it.op, it.a, it.b, zero_flag, it.exp_z);
                end
                n_checks++;
                if (ovf_flag !== it.exp_v) begin
                    n_fail++;
                    $display("FAIL %s op=%b a=%h b=%h ovf actual=%b expected=%b",
                             it.v_tag, it.op, it.a, it.b, ovf_flag, it.exp_v);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corner [5];
        corner[0] = '0;
        corner[1] = {{(W-1){1'b0}}, 1'b1};
        corner[2] = '1;
        corner[3] = {1'b0, {(W-1){1'b1}}};
        corner[4] = {1'b1, {(W-1){1'b0}}};

        // Reset-time check: all-zero inputs give zero result, zero flag set.
        drive(3'b000, '0, '0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1, R2 patterns
        drive(3'b000, 32'hF0F0_A5A5, 32'h0FF0_FFFF);
        drive(3'b001, 32'hF000_0001, 32'h0000_A5A0);
        // R3 / R7: positive overflow, negative overflow, carry-out without overflow
        drive(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
        drive(3'b010, 32'h8000_0000, 32'hFFFF_FFFF);
        drive(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
        // R4 / R8 / R6: overflow both ways, equal operands
        drive(3'b110, 32'h8000_0000, 32'h0000_0001);
        drive(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        drive(3'b110, 32'h1234_5678, 32'h1234_5678);
        // R5: signed compare, including overflowing subtraction
        drive(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);
        drive(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
        drive(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
        // R10: unused codes
        drive(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive(3'b100, 32'h1234_0000, 32'h0000_5678);
        drive(3'b101, 32'h8000_0000, 32'h8000_0000);

        // Corner crossing over every code
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    drive(op[2:0], corner[i], corner[j]);

        // Random operands
        for (int k = 0; k < 400; k++) begin
            logic [2:0] rop;
            rop = 3'($urandom_range(0, 7));
            drive(rop, W'($urandom), W'($urandom));
        end

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule